// File: doc/BRIEF.md
# Exception Reset and Interrupt Policy Controller

This block sits beside a processor core's exception logic. It holds a 32-bit policy register and uses it to decide what happens when the core reports a fault. Two groups of fault events can each be turned into a system reset request. Events of any other kind go on to normal exception processing. For each reported event the block emits exactly one single-cycle pulse one clock later: either a reset request or a permission to proceed.

The block also handles interrupt entry. An entry request arrives on a valid/ready stream. Depending on the policy, the block may first run an acknowledge handshake with the interrupt controller to fetch the vector number. It then returns the new priority mask and the vector on an output valid/ready stream. The input stream accepts a new entry only while the block is idle. The output stream holds its data stable until the consumer takes it, so a slow consumer stalls further entries.

A level-7 edge detector keeps the highest level recognisable even when the current mask is 7. The policy register is written by the core in supervisor mode or by the debug port. A write from user mode is refused and reported as a privilege violation.

Top module: `erp_ctrl`

## Requirements
- R1: After reset `cfg_rdata` is 0. Only bits 31, 30, 29, 28, 25 and 24 can be written; every other bit always reads 0.
- R2: A write with `cpu_wr_en`=1 and `cpu_supv`=1 updates the register at the next clock edge. A debug write updates it only when `dbg_idx` is 0x802; any other index is ignored. When both writes happen in the same cycle, the debug write wins.
- R3: A write with `cpu_wr_en`=1 and `cpu_supv`=0 leaves the register unchanged. It produces a one-cycle `priv_viol` pulse in the cycle after the attempt.
- R4: The `exc_kind` codes for the address group are 0 (address error), 1 (bus error), 2 (return-frame format error) and 3 (double fault). An event in this group raises `rst_req` when bit 31 is 0, and raises `exc_go` instead when bit 31 is 1.
- R5: The `exc_kind` codes for the instruction group are 4 (illegal instruction), 5 (unimplemented line-A opcode), 6 (unimplemented line-F opcode) and 7 (privilege violation). An event in this group raises `rst_req` when bit 30 is 0, and raises `exc_go` when bit 30 is 1.
- R6: Kind 8 (the dedicated illegal opcode) and kinds 9 to 15 never raise `rst_req`. Every event with `exc_valid` produces exactly one of `rst_req` and `exc_go`, as a one-cycle pulse in the next cycle.
- R7: `done_mask` is 7 when bit 28 was 1 at acceptance. Otherwise it is the accepted `ent_level`.
- R8: When bit 29 was 1 at acceptance, `ack_req` rises in the cycle after acceptance, with `ack_level` set to the accepted level. It stays high until a cycle with `ack_ready`=1, and `done_vec` then takes `ack_vec` from that cycle. When bit 29 was 0, `ack_req` stays low, `done_valid` rises in the cycle after acceptance, and `done_vec` is the accepted `ent_vec`.
- R9: `ent_ready` is 1 only while no entry is in progress. `done_valid`, `done_mask` and `done_vec` stay stable until a cycle with `done_ready`=1, after which `done_valid` drops and `ent_ready` returns to 1.
- R10: `irq_take` is 1 whenever `irq_level` is greater than `cur_mask`.
- R11: A change of `irq_level` from below 7 to 7 sets a pending flag one cycle later, which drives `irq_take` to 1 even with `cur_mask`=7. The flag clears when an entry with level 7 is accepted, and a level that stays at 7 does not set it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | Core write strobe for the policy register |
| cpu_supv | input | 1 | Core is in supervisor mode |
| cpu_wr_data | input | 32 | Core write data |
| dbg_wr_en | input | 1 | Debug write strobe |
| dbg_idx | input | 12 | Debug register index |
| dbg_wr_data | input | 32 | Debug write data |
| cfg_rdata | output | 32 | Current policy register value |
| priv_viol | output | 1 | Refused user-mode write pulse |
| exc_valid | input | 1 | Exception event strobe |
| exc_kind | input | 4 | Exception kind code |
| rst_req | output | 1 | System reset request pulse |
| exc_go | output | 1 | Proceed with exception processing pulse |
| irq_level | input | 3 | Current request level from interrupt controller |
| cur_mask | input | 3 | Current interrupt priority mask |
| irq_take | output | 1 | An interrupt should be taken |
| ent_valid | input | 1 | Interrupt entry request valid |
| ent_ready | output | 1 | Entry request accepted when high |
| ent_level | input | 3 | Level of interrupt being entered |
| ent_vec | input | 8 | Vector latched when request was signalled |
| ack_req | output | 1 | Acknowledge cycle request |
| ack_level | output | 3 | Level being acknowledged |
| ack_ready | input | 1 | Acknowledge response ready |
| ack_vec | input | 8 | Vector returned by acknowledge |
| done_valid | output | 1 | Entry result valid |
| done_ready | input | 1 | Consumer takes entry result |
| done_mask | output | 3 | New interrupt priority mask |
| done_vec | output | 8 | Vector number for the entry |

## Verification
A corrupted policy bit shows up one cycle after the next fault event: a reset request appears in place of a proceed pulse, or the reverse. It also shows on `cfg_rdata` at once. A wrong entry state shows within one cycle as a missing or duplicated acknowledge request, an early `ent_ready`, or a `done_vec` that changes while the output is stalled. A stuck or lost level-7 pending flag shows on `irq_take` in the cycle after the level-7 edge or after the level-7 entry is accepted.

// File: rtl/erp_pkg.sv
package erp_pkg;
  typedef enum logic [3:0] {
    EK_ADDR_ERR  = 4'd0,
    EK_BUS_ERR   = 4'd1,
    EK_FRAME_ERR = 4'd2,
    EK_DBL_FAULT = 4'd3,
    EK_ILL_INSN  = 4'd4,
    EK_LINE_A    = 4'd5,
    EK_LINE_F    = 4'd6,
    EK_PRIV      = 4'd7,
    EK_ILL_OP    = 4'd8
  } exc_kind_e;

  localparam int unsigned POS_ADDR_RST_OFF = 31;
  localparam int unsigned POS_INSN_RST_OFF = 30;
  localparam int unsigned POS_ACK_CYCLE    = 29;
  localparam int unsigned POS_FORCE_MAX    = 28;

  typedef enum logic [1:0] {
    ENT_IDLE = 2'd0,
    ENT_ACK  = 2'd1,
    ENT_OUT  = 2'd2
  } ent_state_e;
endpackage

// File: rtl/erp_cfg_reg.sv
module erp_cfg_reg #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 12,
  parameter logic [IDX_W-1:0]  DBG_IDX = 12'h802,
  parameter logic [DATA_W-1:0] WMASK   = 32'hF300_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic              cpu_supv,
  input  logic [DATA_W-1:0] cpu_wr_data,
  input  logic              dbg_wr_en,
  input  logic [IDX_W-1:0]  dbg_idx,
  input  logic [DATA_W-1:0] dbg_wr_data,
  output logic [DATA_W-1:0] cfg_q,
  output logic              priv_viol
);
  logic dbg_hit, sup_hit;

  assign dbg_hit = dbg_wr_en && (dbg_idx == DBG_IDX);
  assign sup_hit = cpu_wr_en && cpu_supv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      priv_viol <= 1'b0;
    end else begin
      priv_viol <= cpu_wr_en && !cpu_supv;
      if (dbg_hit)      cfg_q <= dbg_wr_data & WMASK;
      else if (sup_hit) cfg_q <= cpu_wr_data & WMASK;
    end
  end
endmodule

// File: rtl/erp_rst_policy.sv
module erp_rst_policy
  import erp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exc_valid,
  input  logic [3:0] exc_kind,
  input  logic       addr_rst_off,
  input  logic       insn_rst_off,
  output logic       rst_req,
  output logic       exc_go
);
  logic grp_addr, grp_insn, to_reset;

  always_comb begin
    grp_addr = exc_kind inside {EK_ADDR_ERR, EK_BUS_ERR, EK_FRAME_ERR, EK_DBL_FAULT};
    grp_insn = exc_kind inside {EK_ILL_INSN, EK_LINE_A, EK_LINE_F, EK_PRIV};
    to_reset = (grp_addr && !addr_rst_off) || (grp_insn && !insn_rst_off);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
      exc_go  <= 1'b0;
    end else begin
      rst_req <= exc_valid && to_reset;
      exc_go  <= exc_valid && !to_reset;
    end
  end
endmodule

// File: rtl/erp_lvl_edge.sv
module erp_lvl_edge #(
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] irq_level,
  input  logic [LVL_W-1:0] cur_mask,
  input  logic             clr,
  output logic             pend,
  output logic             irq_take
);
  localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};
  logic [LVL_W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= TOP;
      pend   <= 1'b0;
    end else begin
      prev_q <= irq_level;
      if (irq_level == TOP && prev_q != TOP) pend <= 1'b1;
      else if (clr)                          pend <= 1'b0;
    end
  end

  assign irq_take = (irq_level > cur_mask) || pend;
endmodule

// File: rtl/erp_int_entry.sv
module erp_int_entry
  import erp_pkg::*;
#(
  parameter int unsigned LVL_W = 3,
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_mode,
  input  logic             force_max,
  input  logic             ent_valid,
  output logic             ent_ready,
  input  logic [LVL_W-1:0] ent_level,
  input  logic [VEC_W-1:0] ent_vec,
  output logic             ack_req,
  output logic [LVL_W-1:0] ack_level,
  input  logic             ack_ready,
  input  logic [VEC_W-1:0] ack_vec,
  output logic             done_valid,
  input  logic             done_ready,
  output logic [LVL_W-1:0] done_mask,
  output logic [VEC_W-1:0] done_vec,
  output logic             accepted
);
  localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};
  ent_state_e       st;
  logic [LVL_W-1:0] lvl_q, mask_q;
  logic [VEC_W-1:0] vec_q;

  assign ent_ready  = (st == ENT_IDLE);
  assign accepted   = ent_valid && ent_ready;
  assign ack_req    = (st == ENT_ACK);
  assign ack_level  = lvl_q;
  assign done_valid = (st == ENT_OUT);
  assign done_mask  = mask_q;
  assign done_vec   = vec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ENT_IDLE;
      lvl_q  <= '0;
      mask_q <= '0;
      vec_q  <= '0;
    end else begin
      unique case (st)
        ENT_IDLE: if (ent_valid) begin
          lvl_q  <= ent_level;
          mask_q <= force_max ? TOP : ent_level;
          vec_q  <= ent_vec;
          st     <= ack_mode ? ENT_ACK : ENT_OUT;
        end
        ENT_ACK: if (ack_ready) begin
          vec_q <= ack_vec;
          st    <= ENT_OUT;
        end
        ENT_OUT: if (done_ready) st <= ENT_IDLE;
        default: st <= ENT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/erp_ctrl.sv
module erp_ctrl
  import erp_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 12,
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic              cpu_supv,
  input  logic [DATA_W-1:0] cpu_wr_data,
  input  logic              dbg_wr_en,
  input  logic [IDX_W-1:0]  dbg_idx,
  input  logic [DATA_W-1:0] dbg_wr_data,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              priv_viol,
  input  logic              exc_valid,
  input  logic [3:0]        exc_kind,
  output logic              rst_req,
  output logic              exc_go,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic [LVL_W-1:0]  cur_mask,
  output logic              irq_take,
  input  logic              ent_valid,
  output logic              ent_ready,
  input  logic [LVL_W-1:0]  ent_level,
  input  logic [VEC_W-1:0]  ent_vec,
  output logic              ack_req,
  output logic [LVL_W-1:0]  ack_level,
  input  logic              ack_ready,
  input  logic [VEC_W-1:0]  ack_vec,
  output logic              done_valid,
  input  logic              done_ready,
  output logic [LVL_W-1:0]  done_mask,
  output logic [VEC_W-1:0]  done_vec
);
  localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};
  localparam logic [DATA_W-1:0] WMASK = (DATA_W'(1) << POS_ADDR_RST_OFF) |
      (DATA_W'(1) << POS_INSN_RST_OFF) | (DATA_W'(1) << POS_ACK_CYCLE) |
      (DATA_W'(1) << POS_FORCE_MAX) | (DATA_W'(3) << 24);

  logic accepted, nmi_pend;

  erp_cfg_reg #(.DATA_W(DATA_W), .IDX_W(IDX_W), .DBG_IDX(IDX_W'(12'h802)),
                .WMASK(WMASK)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_supv(cpu_supv),
    .cpu_wr_data(cpu_wr_data), .dbg_wr_en(dbg_wr_en), .dbg_idx(dbg_idx),
    .dbg_wr_data(dbg_wr_data), .cfg_q(cfg_rdata), .priv_viol(priv_viol));

  erp_rst_policy u_pol (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_kind(exc_kind),
    .addr_rst_off(cfg_rdata[POS_ADDR_RST_OFF]),
    .insn_rst_off(cfg_rdata[POS_INSN_RST_OFF]),
    .rst_req(rst_req), .exc_go(exc_go));

  erp_lvl_edge #(.LVL_W(LVL_W)) u_l7 (
    .clk(clk), .rst_n(rst_n), .irq_level(irq_level), .cur_mask(cur_mask),
    .clr(accepted && ent_level == TOP), .pend(nmi_pend), .irq_take(irq_take));

  erp_int_entry #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_ent (
    .clk(clk), .rst_n(rst_n),
    .ack_mode(cfg_rdata[POS_ACK_CYCLE]), .force_max(cfg_rdata[POS_FORCE_MAX]),
    .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_level(ent_level),
    .ent_vec(ent_vec), .ack_req(ack_req), .ack_level(ack_level),
    .ack_ready(ack_ready), .ack_vec(ack_vec), .done_valid(done_valid),
    .done_ready(done_ready), .done_mask(done_mask), .done_vec(done_vec),
    .accepted(accepted));
endmodule

// File: rtl/erp_chk.sv
module erp_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 12,
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned VEC_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_wr_en,
  input logic              cpu_supv,
  input logic              dbg_wr_en,
  input logic [IDX_W-1:0]  dbg_idx,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              priv_viol,
  input logic              exc_valid,
  input logic [3:0]        exc_kind,
  input logic              rst_req,
  input logic              exc_go,
  input logic [LVL_W-1:0]  irq_level,
  input logic              nmi_pend,
  input logic              ack_req,
  input logic [LVL_W-1:0]  ack_level,
  input logic              ack_ready,
  input logic              done_valid,
  input logic              done_ready,
  input logic [LVL_W-1:0]  done_mask,
  input logic [VEC_W-1:0]  done_vec
);
  localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};

  // R3
  user_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_en && !cpu_supv && !(dbg_wr_en && dbg_idx == IDX_W'(12'h802)))
      |=> $stable(cfg_rdata));

  // R3
  user_write_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_en && !cpu_supv) |=> priv_viol);

  // R4
  addr_group_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_kind < 4'd4 && !cfg_rdata[31]) |=> rst_req);

  // R6
  single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_req, exc_go}));

  // R6
  event_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (rst_req || exc_go));

  // R6
  ill_op_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_kind == 4'd8) |=> !rst_req);

  // R8
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !ack_ready) |=> (ack_req && $stable(ack_level)));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_ready) |=>
      (done_valid && $stable(done_mask) && $stable(done_vec)));

  // R11
  edge_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_pend) |-> ($past(irq_level) == TOP));
endmodule

bind erp_ctrl erp_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W), .LVL_W(LVL_W),
                        .VEC_W(VEC_W)) u_chk (.*);

// File: tb/test_erp_ctrl.sv
module test_erp_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_wr_en, cpu_supv, dbg_wr_en;
  logic [31:0] cpu_wr_data, dbg_wr_data, cfg_rdata;
  logic [11:0] dbg_idx;
  logic        priv_viol, exc_valid, rst_req, exc_go;
  logic [3:0]  exc_kind;
  logic [2:0]  irq_level, cur_mask, ent_level, ack_level, done_mask;
  logic        irq_take, ent_valid, ent_ready, ack_req, ack_ready;
  logic        done_valid, done_ready;
  logic [7:0]  ent_vec, ack_vec, done_vec;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  erp_ctrl i_erp_ctrl (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  task automatic dbg_write(input logic [11:0] idx, input logic [31:0] d);
    dbg_wr_en = 1; dbg_idx = idx; dbg_wr_data = d;
    cyc();
    dbg_wr_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 0; cpu_wr_en = 0; cpu_supv = 0; cpu_wr_data = 0;
    dbg_wr_en = 0; dbg_idx = 0; dbg_wr_data = 0; exc_valid = 0; exc_kind = 0;
    irq_level = 0; cur_mask = 7; ent_valid = 0; ent_level = 0; ent_vec = 0;
    ack_ready = 0; ack_vec = 0; done_ready = 0;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R1 reset state
    chk("R1 reset cfg", cfg_rdata, 0);
    chk("R6 reset rst_req", {31'd0, rst_req}, 0);
    chk("R6 reset exc_go", {31'd0, exc_go}, 0);
    chk("R9 reset ent_ready", {31'd0, ent_ready}, 1);
    chk("R9 reset done_valid", {31'd0, done_valid}, 0);
    chk("R10 reset irq_take", {31'd0, irq_take}, 0);

    // R1 R2 supervisor writes, masking
    cpu_wr_en = 1; cpu_supv = 1; cpu_wr_data = 32'hFFFF_FFFF;
    cyc(); cpu_wr_en = 0;
    chk("R1 writable bits", cfg_rdata, 32'hF300_0000);
    cpu_wr_en = 1; cpu_wr_data = 32'h5A5A_5A5A;
    cyc(); cpu_wr_en = 0;
    chk("R2 supervisor write", cfg_rdata, 32'h5200_0000);
    // R2 wrong debug index ignored
    dbg_write(12'h801, 32'hFFFF_FFFF);
    chk("R2 wrong index ignored", cfg_rdata, 32'h5200_0000);
    // R2 debug wins
    cpu_wr_en = 1; cpu_supv = 1; cpu_wr_data = 32'h1000_0000;
    dbg_wr_en = 1; dbg_idx = 12'h802; dbg_wr_data = 32'h0100_0000;
    cyc(); cpu_wr_en = 0; dbg_wr_en = 0;
    chk("R2 debug priority", cfg_rdata, 32'h0100_0000);
    // R3 user write refused
    cpu_wr_en = 1; cpu_supv = 0; cpu_wr_data = 32'hFFFF_FFFF;
    cyc(); cpu_wr_en = 0;
    chk("R3 user write cfg", cfg_rdata, 32'h0100_0000);
    chk("R3 priv_viol pulse", {31'd0, priv_viol}, 1);
    cyc();
    chk("R3 priv_viol ends", {31'd0, priv_viol}, 0);

    // R4 R5 R6 policy sweep
    for (int c = 0; c < 4; c++) begin
      dbg_write(12'h802, {c[1], c[0], 30'd0});
      for (int k = 0; k < 16; k++) begin
        logic er;
        er = (k < 4) ? !c[1] : (k < 8) ? !c[0] : 1'b0;
        exc_valid = 1; exc_kind = 4'(k);
        cyc(); exc_valid = 0;
        chk(k < 4 ? "R4 rst_req" : k < 8 ? "R5 rst_req" : "R6 rst_req",
            {31'd0, rst_req}, {31'd0, er});
        chk("R6 exc_go", {31'd0, exc_go}, {31'd0, !er});
      end
      cyc();
      chk("R6 pulse ends", {30'd0, rst_req, exc_go}, 0);
    end

    // R7 R8 R9 entry sweep
    for (int b = 0; b < 4; b++) begin
      dbg_write(12'h802, {2'b00, b[1], b[0], 28'd0});
      for (int lv = 1; lv < 8; lv++) begin
        for (int d = 0; d < 3; d++) begin
          logic [7:0] ev;
          ent_valid = 1; ent_level = 3'(lv); ent_vec = 8'(8'h10 + lv);
          chk("R9 ready idle", {31'd0, ent_ready}, 1);
          cyc(); ent_valid = 0;
          chk("R9 busy", {31'd0, ent_ready}, 0);
          if (b[1]) begin
            chk("R8 ack_req", {31'd0, ack_req}, 1);
            chk("R8 ack_level", {29'd0, ack_level}, lv);
            chk("R8 no early done", {31'd0, done_valid}, 0);
            for (int w = 0; w < d; w++) begin
              cyc();
              chk("R8 ack held", {31'd0, ack_req}, 1);
            end
            ev = 8'(8'hA0 + lv * 3 + d);
            ack_ready = 1; ack_vec = ev;
            cyc(); ack_ready = 0; ack_vec = 0;
            chk("R8 ack released", {31'd0, ack_req}, 0);
          end else begin
            chk("R8 no ack", {31'd0, ack_req}, 0);
            ev = 8'(8'h10 + lv);
          end
          chk("R8 done_valid", {31'd0, done_valid}, 1);
          chk("R7 done_mask", {29'd0, done_mask}, b[0] ? 7 : lv);
          chk("R8 done_vec", {24'd0, done_vec}, {24'd0, ev});
          for (int w = 0; w < d; w++) begin
            cyc();
            chk("R9 held valid", {31'd0, done_valid}, 1);
            chk("R9 held vec", {24'd0, done_vec}, {24'd0, ev});
          end
          done_ready = 1;
          cyc(); done_ready = 0;
          chk("R9 drained", {31'd0, done_valid}, 0);
          chk("R9 ready again", {31'd0, ent_ready}, 1);
        end
      end
    end

    // R10 level compare sweep
    dbg_write(12'h802, 32'd0);
    for (int m = 0; m < 8; m++) begin
      for (int lv = 0; lv < 7; lv++) begin
        cur_mask = 3'(m); irq_level = 3'(lv);
        #1;
        chk("R10 irq_take", {31'd0, irq_take}, {31'd0, lv > m});
      end
    end

    // R11 level-7 edge
    cur_mask = 7; irq_level = 3;
    cyc();
    chk("R11 below 7", {31'd0, irq_take}, 0);
    irq_level = 7;
    #1;
    chk("R11 not yet", {31'd0, irq_take}, 0);
    cyc();
    chk("R11 edge pending", {31'd0, irq_take}, 1);
    cyc(); cyc();
    chk("R11 pending held", {31'd0, irq_take}, 1);
    ent_valid = 1; ent_level = 7; ent_vec = 8'h77;
    cyc(); ent_valid = 0;
    chk("R11 cleared on entry", {31'd0, irq_take}, 0);
    done_ready = 1; cyc(); done_ready = 0;
    cyc();
    chk("R11 steady 7 no retrigger", {31'd0, irq_take}, 0);
    irq_level = 2; cyc(); irq_level = 7; cyc();
    chk("R11 new edge", {31'd0, irq_take}, 1);

    summary();
  end
endmodule